// File: doc/BRIEF.md
# Two-Stage Triggered Converter Scan Sequencer

This block controls a multi-channel successive-approximation converter that is started only by an active-low external trigger pin, and never by software. The trigger pin is resynchronised to the system clock and its high-to-low transitions are turned into single-cycle strobes. The first accepted strobe converts channel 0 alone. The block then parks until a second strobe arrives, which launches one sweep of the remaining channels of the selected group in ascending order. Strobes that arrive while a conversion is running are dropped.

For each channel the sequencer emits a one-cycle start strobe together with a channel index. It then waits for the converter's done handshake, and on that handshake raises the write enable of the matching result register. When the last channel of the sweep completes, a single-cycle interrupt pulse is issued and the block returns to idle. A trigger edge after that point counts as a fresh channel-0 start. Clearing the enable input halts everything within one clock. The analog converter and the register bus are outside the block.

The FSM states are IDLE, CONV_CH0 (channel 0 converting), WAIT_SECOND (channel 0 done, waiting for the second edge) and SWEEP (channels 1 up to the group end converting). The transitions are:
- IDLE to CONV_CH0 on a trigger strobe.
- CONV_CH0 to WAIT_SECOND on done.
- WAIT_SECOND to SWEEP on a trigger strobe.
- SWEEP to SWEEP on done for a channel that is not the last.
- SWEEP to IDLE on done for the last channel.
- Any state to IDLE when the enable is low.

Top module: `trig_scan_seq`

## Requirements
- R1: The trigger pin passes through two synchroniser flops. A high-to-low change of the pin that is sampled at clock edge n is acted on by the state machine at edge n+2. `conv_start` is then high in the cycle that follows edge n+2, and each edge is acted on once only.
- R2: In IDLE with `run_en` high, a trigger strobe starts a conversion of channel 0 only (`conv_start` high for one cycle, `conv_chan` = 0), and `busy` rises.
- R3: After the channel-0 done handshake, the block waits with `busy` low and issues no start until a second strobe. That strobe starts a sweep at channel 1, and each later done starts the next higher channel.
- R4: A trigger strobe during CONV_CH0 or SWEEP has no effect on the state, the channel order or the outputs.
- R5: A trigger strobe after a sweep has completed starts a new channel-0 conversion.
- R6: `grp_sel` codes 0, 1, 2 and 3 select 2, 4, 6 and 8 channels, starting at channel 0. The code is captured when channel 0 starts, so changes later in the scan have no effect.
- R7: `sweep_irq` is a one-cycle pulse in the cycle after the last channel's done, and `busy` is low in that same cycle.
- R8: `res_we` is one-hot, with bit k high in the cycle where `conv_done` arrives while channel k is converting. It stays zero for a done that arrives outside a conversion.
- R9: With `run_en` low the block returns to IDLE at the next clock, and strobes are ignored. Raising `run_en` by itself starts nothing.
- R10: `busy` is high exactly while in CONV_CH0 or SWEEP.
- R11: While reset is asserted, `busy`, `conv_start`, `res_we` and `sweep_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_n | input | 1 | Raw external trigger pin, active on the falling edge |
| run_en | input | 1 | Enable; low halts and returns to IDLE |
| grp_sel | input | SELW | Channel group size code |
| conv_done | input | 1 | One-cycle done handshake from the converter |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| conv_chan | output | CW | Channel index for the current conversion |
| res_we | output | NCH | Per-channel result register write enables |
| busy | output | 1 | Conversion in progress |
| sweep_irq | output | 1 | Sweep-complete interrupt pulse |

## Verification
The assertions assume that `conv_done` is a single-cycle pulse that comes some cycles after a start, and no sooner than the cycle after it, and that `trig_n` is idle high during reset. The converter model in the bench returns done a fixed number of cycles after each start, which keeps every handshake well formed. Trigger pulses are held low for two clocks so the synchroniser always registers them. Extra pulses are deliberately placed inside running conversions, and `grp_sel` is changed mid-sweep.

// File: rtl/tss_pkg.sv
package tss_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV0 = 2'd1,
        ST_WAIT2 = 2'd2,
        ST_SWEEP = 2'd3
    } seq_state_t;
endpackage

// File: rtl/tss_trig_sync.sv
module tss_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_stb
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_n};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall_stb = prev_q & ~sync_q[STAGES-1];

    // R1
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb);
endmodule

// File: rtl/tss_chan_ctr.sv
module tss_chan_ctr #(
    parameter int NCH  = 8,
    parameter int SELW = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     ld_one,
    input  logic                     inc,
    input  logic [SELW-1:0]          grp_sel,
    output logic [$clog2(NCH)-1:0]   chan,
    output logic                     is_last
);
    localparam int CW   = $clog2(NCH);
    localparam int STEP = NCH >> SELW;

    logic [SELW-1:0] grp_q;
    logic [CW-1:0]   chan_q;
    logic [CW-1:0]   last_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q  <= '0;
            chan_q <= '0;
        end else if (clr) begin
            grp_q  <= grp_sel;
            chan_q <= '0;
        end else if (ld_one) begin
            chan_q <= CW'(1);
        end else if (inc) begin
            chan_q <= chan_q + 1'b1;
        end
    end

    always_comb begin
        last_idx = CW'((int'(grp_q) + 1) * STEP - 1);
    end

    assign chan    = chan_q;
    assign is_last = (chan_q == last_idx);

    // R6
    no_step_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !is_last);
endmodule

// File: rtl/trig_scan_seq.sv
module trig_scan_seq
    import tss_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int SELW = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   trig_n,
    input  logic                   run_en,
    input  logic [SELW-1:0]        grp_sel,
    input  logic                   conv_done,
    output logic                   conv_start,
    output logic [$clog2(NCH)-1:0] conv_chan,
    output logic [NCH-1:0]         res_we,
    output logic                   busy,
    output logic                   sweep_irq
);
    localparam int CW = $clog2(NCH);

    seq_state_t    state_q, state_d;
    logic          trig_fall;
    logic          ctr_clr, ctr_ld1, ctr_inc;
    logic          start_d, irq_d;
    logic          start_q, irq_q;
    logic [CW-1:0] chan;
    logic          is_last;

    tss_trig_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (trig_n),
        .fall_stb (trig_fall)
    );

    tss_chan_ctr #(.NCH(NCH), .SELW(SELW)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctr_clr),
        .ld_one  (ctr_ld1),
        .inc     (ctr_inc),
        .grp_sel (grp_sel),
        .chan    (chan),
        .is_last (is_last)
    );

    // next state and sequencing controls
    always_comb begin
        state_d = state_q;
        ctr_clr = 1'b0;
        ctr_ld1 = 1'b0;
        ctr_inc = 1'b0;
        start_d = 1'b0;
        irq_d   = 1'b0;
        if (!run_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (trig_fall) begin
                        state_d = ST_CONV0;
                        ctr_clr = 1'b1;
                        start_d = 1'b1;
                    end
                end
                ST_CONV0: begin
                    if (conv_done) state_d = ST_WAIT2;
                end
                ST_WAIT2: begin
                    if (trig_fall) begin
                        state_d = ST_SWEEP;
                        ctr_ld1 = 1'b1;
                        start_d = 1'b1;
                    end
                end
                ST_SWEEP: begin
                    if (conv_done) begin
                        if (is_last) begin
                            state_d = ST_IDLE;
                            irq_d   = 1'b1;
                        end else begin
                            ctr_inc = 1'b1;
                            start_d = 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            start_q <= start_d;
            irq_q   <= irq_d;
        end
    end

    assign busy       = (state_q == ST_CONV0) || (state_q == ST_SWEEP);
    assign conv_start = start_q;
    assign conv_chan  = chan;
    assign sweep_irq  = irq_q;

    always_comb begin
        res_we = '0;
        if (busy && conv_done) res_we[chan] = 1'b1;
    end

    // R2
    ch0_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start && state_q == ST_CONV0 |-> conv_chan == '0);
    // R3
    sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start && state_q == ST_SWEEP |-> conv_chan != '0);
    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_irq |=> !sweep_irq);
    // R7
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_irq |-> !busy);
    // R8
    we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_we));
    // R9
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !busy && !conv_start);
endmodule

// File: tb/trig_scan_seq_tb.sv
`timescale 1ns/100ps
module trig_scan_seq_tb;
    localparam int NCH = 8;
    localparam int LAT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_n = 1'b1;
    logic       run_en = 1'b0;
    logic [1:0] grp_sel = 2'd3;
    logic       conv_done = 1'b0;
    logic       conv_start;
    logic [2:0] conv_chan;
    logic [7:0] res_we;
    logic       busy;
    logic       sweep_irq;

    int n_cmp = 0;
    int n_bad = 0;
    int irq_seen = 0;
    int we_seen = 0;
    int start_seen = 0;

    always #2.5 clk = ~clk;

    trig_scan_seq #(.NCH(NCH), .SELW(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .run_en(run_en),
        .grp_sel(grp_sel), .conv_done(conv_done), .conv_start(conv_start),
        .conv_chan(conv_chan), .res_we(res_we), .busy(busy), .sweep_irq(sweep_irq)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: 0 idle, 1 ch0, 2 waiting, 3 sweeping
    int m_st = 0;
    int m_ch = 0;
    int m_grp = 0;
    bit m_start = 0;
    bit m_irq = 0;
    bit rawq[$] = '{1'b1, 1'b1, 1'b1};

    always @(posedge clk) begin
        bit stb;
        stb = rawq[$-2] && !rawq[$-1];
        m_start = 0;
        m_irq = 0;
        if (!rst_n) begin
            m_st = 0;
            m_ch = 0;
            m_grp = 0;
        end else if (!run_en) begin
            m_st = 0;
        end else begin
            case (m_st)
                0: if (stb) begin m_st = 1; m_ch = 0; m_grp = int'(grp_sel); m_start = 1; end
                1: if (conv_done) m_st = 2;
                2: if (stb) begin m_st = 3; m_ch = 1; m_start = 1; end
                default: if (conv_done) begin
                    if (m_ch == 2 * (m_grp + 1) - 1) begin m_st = 0; m_irq = 1; end
                    else begin m_ch++; m_start = 1; end
                end
            endcase
        end
        rawq.push_back(trig_n);
        if (rawq.size() > 8) void'(rawq.pop_front());
    end

    // converter model and per-cycle comparison
    int cnt = 0;
    always @(negedge clk) begin
        bit e_busy;
        int e_we;
        #0.5;
        if (!rst_n) begin
            cnt = 0;
            conv_done = 1'b0;
        end else begin
            if (conv_start) cnt = LAT;
            else if (cnt > 0) cnt--;
            conv_done = (cnt == 1);
        end
        #0.5;
        if (rst_n) begin
            e_busy = (m_st == 1) || (m_st == 3);
            e_we = (e_busy && conv_done) ? (1 << m_ch) : 0;
            chk(conv_start == m_start, "R1/R2/R4 conv_start", int'(conv_start), int'(m_start));
            if (m_start) chk(int'(conv_chan) == m_ch, "R3/R6 conv_chan", int'(conv_chan), m_ch);
            chk(int'(res_we) == e_we, "R8 res_we", int'(res_we), e_we);
            chk(busy == e_busy, "R10 busy", int'(busy), int'(e_busy));
            chk(sweep_irq == m_irq, "R7 sweep_irq", int'(sweep_irq), int'(m_irq));
            if (sweep_irq) irq_seen++;
            if (conv_start) start_seen++;
            we_seen += $countones(res_we);
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        @(negedge clk); trig_n = 1'b0;
        wait_cyc(2);
        trig_n = 1'b1;
        wait_cyc(1);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        wait_cyc(4);
        // R11 reset state
        chk(!busy && !conv_start && res_we == 0 && !sweep_irq, "R11 reset outputs", int'(busy), 0);
        rst_n = 1'b1;
        wait_cyc(2);
        run_en = 1'b1;
        wait_cyc(10);
        // R9: enabling alone starts nothing
        chk(start_seen == 0, "R9 no start on enable", start_seen, 0);
        for (int g = 0; g < 4; g++) begin
            int irq0, we0;
            irq0 = irq_seen;
            we0 = we_seen;
            grp_sel = 2'(g);
            pulse();
            pulse();                 // R4: lands during channel 0
            wait_cyc(20);
            // R3: parked after channel 0
            chk(!busy, "R3 waiting for second edge", int'(busy), 0);
            pulse();
            pulse();                 // R4: lands during sweep
            grp_sel = 2'(3 - g);     // R6: late change ignored
            wait_cyc(90);
            chk(irq_seen - irq0 == 1, "R7 one irq per scan", irq_seen - irq0, 1);
            chk(we_seen - we0 == 2 * (g + 1), "R6 writes per scan", we_seen - we0, 2 * (g + 1));
        end
        // R5: edge after completion restarts channel 0
        pulse();
        wait_cyc(3);
        chk(busy, "R5 new channel-0 start", int'(busy), 1);
        wait_cyc(20);
        pulse();
        wait_cyc(12);
        run_en = 1'b0;
        wait_cyc(1);
        chk(!busy, "R9 halt on disable", int'(busy), 0);
        pulse();
        wait_cyc(20);
        chk(!busy, "R9 edge ignored while disabled", int'(busy), 0);
        run_en = 1'b1;
        wait_cyc(20);
        chk(!busy, "R9 stays idle after re-enable", int'(busy), 0);
        finish_run();
    end
endmodule